// File: doc/BRIEF.md
# Push Sequence Coalescer

This block sits in a decoded micro-op stream between decode and issue. Each incoming operation is either a push, which names a data register, or some other operation, which is carried along with an opaque payload. Pushes that arrive one after another are gathered into a short run. The run is then rewritten as a set of independent stores. Each store addresses a fixed negative offset from the stack pointer as it was before the run. One combined stack-pointer subtraction follows the stores.

Without the rewrite, every push would depend on the stack-pointer update made by the push before it. After the rewrite, the stores no longer depend on each other or on the pointer. A later issue stage can therefore send them all in the same cycle, and only one pointer write remains.

Both sides use valid/ready handshakes. A flush input forces a partly gathered run out early, for example at a branch or an interrupt boundary.

Top module: `push_coal`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0 and in_ready is 1 while flush is low.
- R2: The k-th push of a run (k from 1) is emitted as kind STORE (out_kind=2) of its register, with out_val equal to -8·k in 16-bit two's complement. Stores leave in push order.
- R3: Directly after the last store of a run, exactly one kind SPSUB (out_kind=3) is emitted, with out_reg equal to the stack-pointer register (31) and out_val equal to 8·n, where n is the run length.
- R4: A non-push operation (in_push=0) ends any run. The run's stores and subtraction are emitted first. The operation then follows as kind OTHER (out_kind=0) with its in_reg and in_val unchanged.
- R5: A run closes by itself when it reaches four pushes. A fifth consecutive push starts a new run.
- R6: While flush is 1, in_ready is 0. A flush that arrives while the block is gathering ends the current run and emits it. A flush with no run pending emits nothing.
- R7: A lone push is emitted as a store at -8 followed by a subtraction of 8.
- R8: A push whose data register is the stack pointer (31) ends the current run. It is then passed through as kind PUSH (out_kind=1) with its register and payload unchanged.
- R9: in_ready is 0 in every cycle in which out_valid is 1.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_kind, out_reg and out_val hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Close and emit the pending run |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Input operation accepted this cycle |
| in_push | input | 1 | 1 = push, 0 = other operation |
| in_reg | input | REG_W | Data register of the operation |
| in_val | input | VAL_W | Opaque payload of the operation |
| out_valid | output | 1 | Output micro-op valid |
| out_ready | input | 1 | Consumer accepts the output micro-op |
| out_kind | output | 2 | 0 OTHER, 1 PUSH, 2 STORE, 3 SPSUB |
| out_reg | output | REG_W | Data register (or stack pointer for SPSUB) |
| out_val | output | VAL_W | Store offset, subtract amount, or passed payload |

## Verification
The hardest situation to reach is a run that is closed by something other than a non-push operation: a flush that lands on a partly filled buffer, or a stack-pointer push that arrives in the middle of a run. Either one has to coincide with consumer back-pressure, so that the held output is checked while the run is still draining. The stimulus reaches these cases in two ways. Directed sequences place a flush after two pushes and a stack-pointer push between ordinary pushes. A seeded random phase then mixes pushes, stack-pointer pushes, other operations and idle-time flushes against a consumer that is ready only part of the time.

// File: rtl/push_coal_pkg.sv
// Shared encodings of the push coalescer.
// Assumes: out_kind is a 2-bit code that the consumer decodes directly.
package push_coal_pkg;
    typedef enum logic [1:0] {
        K_OTHER = 2'd0,
        K_PUSH  = 2'd1,
        K_STORE = 2'd2,
        K_SPSUB = 2'd3
    } out_kind_e;

    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_DRAIN   = 2'd1,
        S_PEND    = 2'd2
    } coal_state_e;
endpackage

// File: rtl/push_coal_runbuf.sv
// Run buffer: holds the data registers of up to DEPTH gathered pushes.
// Assumes: the parent never writes while full and never writes and clears
// in the same cycle. Slot i is written when count equals i.
module push_coal_runbuf #(
    parameter int REG_W = 5,
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_reg,
    output logic [CNT_W-1:0] count
);
    logic [REG_W-1:0] slot_w [DEPTH];
    logic [CNT_W-1:0] count_q;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [REG_W-1:0] q;
        // Capture the register of the push that lands in this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 q <= '0;
            else if (wr_en && count_q == CNT_W'(gi))    q <= wr_reg;
        end
        assign slot_w[gi] = q;
    end

    // Track the number of gathered pushes.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (clr)   count_q <= '0;
        else if (wr_en) count_q <= count_q + 1'b1;
    end

    // Select the slot named by rd_idx; zero beyond the last slot.
    always_comb begin
        rd_reg = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == CNT_W'(i)) rd_reg = slot_w[i];
        end
    end

    assign count = count_q;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (count_q < CNT_W'(DEPTH)));
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/push_coal_fmt.sv
// Drain formatter: turns drain position idx of a run of length count into a
// store (idx < count) or the closing stack-pointer subtraction (idx == count).
// Assumes: idx <= count; purely combinational.
module push_coal_fmt #(
    parameter int REG_W      = 5,
    parameter int VAL_W      = 16,
    parameter int CNT_W      = 3,
    parameter int SLOT_BYTES = 8,
    parameter int SP_REG     = 31
) (
    input  logic [CNT_W-1:0] idx,
    input  logic [CNT_W-1:0] count,
    input  logic [REG_W-1:0] store_reg,
    output logic [1:0]       kind,
    output logic [REG_W-1:0] reg_o,
    output logic [VAL_W-1:0] val_o
);
    import push_coal_pkg::*;

    // Build either the store at -(idx+1)*SLOT_BYTES or the combined subtraction.
    always_comb begin
        if (idx == count) begin
            kind  = K_SPSUB;
            reg_o = REG_W'(SP_REG);
            val_o = VAL_W'(SLOT_BYTES * int'(count));
        end else begin
            kind  = K_STORE;
            reg_o = store_reg;
            val_o = VAL_W'(-(SLOT_BYTES * (int'(idx) + 1)));
        end
    end
endmodule

// File: rtl/push_coal.sv
// Push coalescer top: gathers consecutive pushes, then drains them as
// independent stores off the unchanged stack pointer plus one subtraction.
// A terminating operation is held and emitted after the run.
// Assumes: ready/valid on both sides; input is refused while draining.
module push_coal
    import push_coal_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int VAL_W      = 16,
    parameter int RUN_MAX    = 4,
    parameter int SLOT_BYTES = 8,
    parameter int SP_REG     = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_push,
    input  logic [REG_W-1:0] in_reg,
    input  logic [VAL_W-1:0] in_val,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_kind,
    output logic [REG_W-1:0] out_reg,
    output logic [VAL_W-1:0] out_val
);
    localparam int CNT_W = $clog2(RUN_MAX + 1);

    coal_state_e      state_q;
    logic [CNT_W-1:0] idx_q;
    logic             pend_q;
    logic             pend_push_q;
    logic [REG_W-1:0] pend_reg_q;
    logic [VAL_W-1:0] pend_val_q;

    logic [CNT_W-1:0] count;
    logic [REG_W-1:0] rd_reg;
    logic [1:0]       fmt_kind;
    logic [REG_W-1:0] fmt_reg;
    logic [VAL_W-1:0] fmt_val;

    logic accept, run_push, buf_wr, term, out_fire, drain_end;

    assign in_ready  = (state_q == S_COLLECT) && !flush;
    assign accept    = in_valid && in_ready;
    assign run_push  = in_push && (in_reg != REG_W'(SP_REG));
    assign buf_wr    = accept && run_push;
    assign term      = accept && !run_push;
    assign out_fire  = out_valid && out_ready;
    assign drain_end = (state_q == S_DRAIN) && out_fire && (idx_q == count);

    push_coal_runbuf #(
        .REG_W(REG_W), .DEPTH(RUN_MAX), .CNT_W(CNT_W)
    ) u_runbuf (
        .clk(clk), .rst_n(rst_n), .clr(drain_end), .wr_en(buf_wr),
        .wr_reg(in_reg), .rd_idx(idx_q), .rd_reg(rd_reg), .count(count)
    );

    push_coal_fmt #(
        .REG_W(REG_W), .VAL_W(VAL_W), .CNT_W(CNT_W),
        .SLOT_BYTES(SLOT_BYTES), .SP_REG(SP_REG)
    ) u_fmt (
        .idx(idx_q), .count(count), .store_reg(rd_reg),
        .kind(fmt_kind), .reg_o(fmt_reg), .val_o(fmt_val)
    );

    // Sequence gathering, draining and the held terminating operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_COLLECT;
            idx_q       <= '0;
            pend_q      <= 1'b0;
            pend_push_q <= 1'b0;
            pend_reg_q  <= '0;
            pend_val_q  <= '0;
        end else begin
            case (state_q)
                S_COLLECT: begin
                    idx_q <= '0;
                    if (term) begin
                        pend_q      <= 1'b1;
                        pend_push_q <= in_push;
                        pend_reg_q  <= in_reg;
                        pend_val_q  <= in_val;
                        state_q     <= (count != '0) ? S_DRAIN : S_PEND;
                    end else if (buf_wr && count == CNT_W'(RUN_MAX - 1)) begin
                        state_q <= S_DRAIN;
                    end else if (flush && count != '0) begin
                        state_q <= S_DRAIN;
                    end
                end
                S_DRAIN: begin
                    if (out_fire) begin
                        if (idx_q == count) state_q <= pend_q ? S_PEND : S_COLLECT;
                        else                idx_q   <= idx_q + 1'b1;
                    end
                end
                S_PEND: begin
                    if (out_fire) begin
                        pend_q  <= 1'b0;
                        state_q <= S_COLLECT;
                    end
                end
                default: state_q <= S_COLLECT;
            endcase
        end
    end

    // Drive the output from the formatter while draining, else the held op.
    always_comb begin
        out_valid = 1'b0;
        out_kind  = K_OTHER;
        out_reg   = '0;
        out_val   = '0;
        if (state_q == S_DRAIN) begin
            out_valid = 1'b1;
            out_kind  = fmt_kind;
            out_reg   = fmt_reg;
            out_val   = fmt_val;
        end else if (state_q == S_PEND) begin
            out_valid = 1'b1;
            out_kind  = pend_push_q ? K_PUSH : K_OTHER;
            out_reg   = pend_reg_q;
            out_val   = pend_val_q;
        end
    end

    assert_no_accept_while_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind)
                                       && $stable(out_reg) && $stable(out_val)));
    assert_flush_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);
    assert_one_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_kind == K_SPSUB) |=> !(out_valid && out_kind == K_SPSUB));
    assert_store_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == K_STORE) |->
            ($signed(out_val) < 0 && $signed(out_val) >= -(SLOT_BYTES * RUN_MAX)));
endmodule

// File: tb/push_coal_bench.sv
module push_coal_bench;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int REG_W = 5, VAL_W = 16, RUN_MAX = 4, SB = 8, SP = 31;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, flush, in_valid, in_ready, in_push, out_valid, out_ready;
    logic [REG_W-1:0] in_reg, out_reg;
    logic [VAL_W-1:0] in_val, out_val;
    logic [1:0] out_kind;

    push_coal u_push_coal (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_push(in_push), .in_reg(in_reg), .in_val(in_val),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_reg(out_reg), .out_val(out_val)
    );

    int checks = 0, fails = 0, rdy_pct = 100;
    bit done = 1'b0, held = 1'b0;
    logic [22:0] held_v;
    logic [22:0] expq[$];
    string tagq[$];
    logic [REG_W-1:0] runq[$];

    function automatic logic [22:0] pk(logic [1:0] k, logic [4:0] r, logic [15:0] v);
        return {k, r, v};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // why: 0 ended by other op, 1 full (R5), 2 flush (R6)
    function automatic void emit_run(int why);
        int n = runq.size();
        string ts, tu;
        if (n == 0) return;
        ts = (n == 1) ? "R7" : (why == 1) ? "R5" : (why == 2) ? "R6" : "R2";
        tu = (n == 1) ? "R7" : (why == 1) ? "R5" : (why == 2) ? "R6" : "R3";
        for (int k = 1; k <= n; k++) begin
            expq.push_back(pk(2'd2, runq[k-1], 16'(-(SB * k))));
            tagq.push_back(ts);
        end
        expq.push_back(pk(2'd3, 5'(SP), 16'(SB * n)));
        tagq.push_back(tu);
        runq.delete();
    endfunction

    task automatic send(bit p, logic [4:0] r, logic [15:0] v);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; in_push = p; in_reg = r; in_val = v;
        do begin
            #0.5;
            ok = in_ready;
            if (!ok) @(negedge clk);
        end while (!ok);
        if (p && r != 5'(SP)) begin
            runq.push_back(r);
            if (runq.size() == RUN_MAX) emit_run(1);
        end else begin
            emit_run(0);
            expq.push_back(pk(p ? 2'd1 : 2'd0, r, v));
            tagq.push_back(p ? "R8" : "R4");
        end
        @(posedge clk);
        #0.1 in_valid = 1'b0;
    endtask

    task automatic do_flush();
        bit was_empty;
        @(negedge clk);
        while (out_valid) @(negedge clk);
        flush = 1'b1;
        #0.5;
        check(!in_ready, "R6", "in_ready during flush", 32'(in_ready), 0);
        was_empty = (runq.size() == 0);
        emit_run(2);
        @(posedge clk);
        #0.1 flush = 1'b0;
        if (was_empty) begin
            @(negedge clk);
            #0.5;
            check(!out_valid, "R6", "output after empty flush", 32'(out_valid), 0);
        end
    endtask

    // Output monitor: random consumer readiness, compares against the model.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            logic [22:0] got;
            out_ready = (($urandom % 100) < rdy_pct);
            #0.5;
            got = {out_kind, out_reg, out_val};
            if (held) check(out_valid && got == held_v, "R10", "held output", 32'(got), 32'(held_v));
            held = out_valid && !out_ready;
            held_v = got;
            if (out_valid) check(!in_ready, "R9", "in_ready while out_valid", 32'(in_ready), 0);
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4", "unexpected output", 32'(got), 0);
                end else begin
                    logic [22:0] e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(got == e, t, "output micro-op", 32'(got), 32'(e));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", expq.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_push = 1'b0;
        in_reg = '0; in_val = '0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0.5;
        check(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 0);
        check(in_ready, "R1", "in_ready after reset", 32'(in_ready), 1);

        // R7: lone push then other op (R4)
        send(1, 5'd3, 16'h0011); send(0, 5'd7, 16'h1234);
        // R2/R3: runs of two and three
        send(1, 5'd1, 16'h0); send(1, 5'd2, 16'h0); send(0, 5'd9, 16'hbeef);
        send(1, 5'd4, 16'h0); send(1, 5'd5, 16'h0); send(1, 5'd6, 16'h0);
        send(0, 5'd10, 16'h00aa);
        // R5: five pushes in a row
        rdy_pct = 60;
        for (int i = 0; i < 5; i++) send(1, 5'(11 + i), 16'h0);
        send(0, 5'd0, 16'h5555);
        // R8: stack-pointer push in the middle of a run
        send(1, 5'd4, 16'h0); send(1, 5'(SP), 16'h7777); send(1, 5'd5, 16'h0);
        send(0, 5'd1, 16'h0001);
        // R6: flush after two pushes, then flush with nothing pending
        send(1, 5'd6, 16'h0); send(1, 5'd7, 16'h0);
        do_flush();
        do_flush();

        // Random phase
        rdy_pct = 70;
        for (int i = 0; i < 1500; i++) begin
            int r = $urandom % 100;
            if (r < 6) do_flush();
            else if (r < 66) send(1, ($urandom % 10 == 0) ? 5'(SP) : 5'($urandom % 31), 16'($urandom));
            else send(0, 5'($urandom), 16'($urandom));
        end
        do_flush();
        for (int i = 0; i < 2000 && (expq.size() != 0 || out_valid); i++) @(posedge clk);
        check(expq.size() == 0, "R4", "pending expected outputs", 32'(expq.size()), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule